// File: doc/BRIEF.md
# Float-to-Integer Converter with Special-Operand Trap

This unit turns one IEEE-754 operand, single or double precision, into a signed 32-bit integer under one of four rounding modes. A caller raises a one-cycle strobe with the operand, a precision select and a rounding mode. One clock later the unit either writes the rounded integer to the destination, together with invalid and inexact cause bits, or it declines the write and raises a trap. It traps when the exponent field of the operand is all ones, which means infinity or NaN. In that case it sets an unimplemented-operation cause bit and pulses the coprocessor interrupt line so that software can handle the operand.

The control is a three-state machine. ST_IDLE means no outcome is presented. ST_WRITE presents a converted result with the write enable high. ST_TRAP presents the exception: interrupt and unimplemented cause high, write enable low. From any state, the next state is chosen in the same way. A strobe with a finite operand leads to ST_WRITE (transition GO_WRITE). A strobe with an infinity or NaN operand leads to ST_TRAP (GO_TRAP). No strobe leads to ST_IDLE (GO_IDLE). Strobes may arrive on consecutive cycles.

Top module: `fp2int_trap_unit`

## Requirements
- R1: While reset is low, and in the first cycle after it, the write enable, the interrupt, all three cause bits and the result are zero.
- R2: With the precision select low, the operand is single precision in bits 31:0. It is infinity or NaN when bits 30:23 are all ones. Bits 63:32 are ignored.
- R3: With the precision select high, the operand is double precision in bits 63:0. It is infinity or NaN when bits 62:52 are all ones.
- R4: For an infinity or NaN operand, the write enable stays low in the outcome cycle and the result output keeps its previous value.
- R5: For an infinity or NaN operand, the unimplemented cause bit and the interrupt are high for exactly the outcome cycle. The invalid and inexact cause bits are low in that cycle.
- R6: For a finite operand, the outcome appears in the cycle after the strobe. In that cycle the write enable is high, the result is the rounded value as a two's-complement 32-bit integer, and the interrupt and unimplemented cause bit are low. Denormal operands are converted by value.
- R7: The rounding mode is encoded 0 = nearest-even, 1 = toward zero, 2 = toward plus infinity, 3 = toward minus infinity.
- R8: In mode 0, a value exactly halfway between two integers rounds to the even one.
- R9: A finite operand whose rounded value lies outside -2^31 to 2^31-1 writes 0x7FFFFFFF and sets the invalid cause bit, for either sign. An exact -2^31 is in range.
- R10: The inexact cause bit is set when rounding discards a nonzero fraction of an in-range value. It is clear for exact conversions and for out-of-range conversions.
- R11: In a cycle that does not follow a strobe, the write enable, the interrupt and all cause bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Conversion strobe |
| in_dbl | input | 1 | 1 = double precision, 0 = single precision |
| in_opnd | input | 64 | Operand; single precision uses bits 31:0 |
| in_rmode | input | 2 | Rounding mode |
| out_wr_en | output | 1 | Destination write enable |
| out_result | output | 32 | Converted integer |
| out_cause_unimpl | output | 1 | Unimplemented-operation cause |
| out_cause_invalid | output | 1 | Out-of-range cause |
| out_cause_inexact | output | 1 | Inexact cause |
| out_irq | output | 1 | Coprocessor interrupt |

## Verification
The hardest outcomes to reach are the ones at the edges of the integer range. Examples are 2147483647.5, which overflows only under some rounding modes, and an exact -2^31, which is legal even though its magnitude exceeds the positive limit. A double operand can land on these values, so directed tasks apply those bit patterns under every rounding mode. They also place a single-precision infinity pattern in the low word of a double operand, and garbage in the upper word of a single operand, to confirm that the precision select alone decides which exponent field is examined.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
    localparam int MANT_W  = 53;
    localparam int EXPS_W  = 13;

    typedef enum logic [1:0] {
        RM_NEAR  = 2'd0,
        RM_ZERO  = 2'd1,
        RM_PLUS  = 2'd2,
        RM_MINUS = 2'd3
    } rmode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_TRAP  = 2'd2
    } cvt_state_e;

    typedef struct packed {
        logic                     sign;
        logic                     special;
        logic signed [EXPS_W-1:0] exp;
        logic [MANT_W-1:0]        mant;
    } opnd_fields_t;
endpackage

// File: rtl/fcvt_field.sv
module fcvt_field
    import fcvt_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] bits_i,
    output opnd_fields_t          fld_o
);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;

    logic [EXP_W-1:0]  exp_raw;
    logic [FRAC_W-1:0] frac_raw;
    logic              hidden;
    logic [EXPS_W-1:0] exp_ext;

    assign exp_raw  = bits_i[EXP_W+FRAC_W-1:FRAC_W];
    assign frac_raw = bits_i[FRAC_W-1:0];
    assign hidden   = |exp_raw;
    assign exp_ext  = EXPS_W'(exp_raw);

    always_comb begin
        fld_o.sign    = bits_i[EXP_W+FRAC_W];
        fld_o.special = &exp_raw;
        // denormals use exponent 1 - bias with no hidden bit
        fld_o.exp     = $signed((hidden ? exp_ext : EXPS_W'(1)) - EXPS_W'(BIAS));
        fld_o.mant    = MANT_W'({hidden, frac_raw}) << (MANT_W - 1 - FRAC_W);
    end
endmodule

// File: rtl/fcvt_unpack.sv
module fcvt_unpack
    import fcvt_pkg::*;
(
    input  logic         dbl_i,
    input  logic [63:0]  opnd_i,
    output opnd_fields_t fld_o
);
    localparam int N_FMT = 2;

    opnd_fields_t fmt_fld [N_FMT];

    for (genvar g = 0; g < N_FMT; g++) begin : g_fmt
        if (g == 0) begin : g_single
            fcvt_field #(.EXP_W(8), .FRAC_W(23)) u_fld (
                .bits_i (opnd_i[31:0]),
                .fld_o  (fmt_fld[g])
            );
        end else begin : g_double
            fcvt_field #(.EXP_W(11), .FRAC_W(52)) u_fld (
                .bits_i (opnd_i),
                .fld_o  (fmt_fld[g])
            );
        end
    end

    assign fld_o = dbl_i ? fmt_fld[1] : fmt_fld[0];
endmodule

// File: rtl/fcvt_round.sv
module fcvt_round
    import fcvt_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  opnd_fields_t     fld_i,
    input  rmode_e           rmode_i,
    output logic [INT_W-1:0] result_o,
    output logic             invalid_o,
    output logic             inexact_o
);
    localparam int SH_W  = MANT_W + INT_W + 2;
    localparam int IP_W  = INT_W + 2;
    localparam int MAG_W = INT_W + 3;
    localparam logic [MAG_W-1:0] POS_LIM = MAG_W'((64'd1 << (INT_W - 1)) - 64'd1);
    localparam logic [MAG_W-1:0] NEG_LIM = MAG_W'(64'd1 << (INT_W - 1));
    localparam logic [INT_W-1:0] SAT_VAL = {1'b0, {(INT_W-1){1'b1}}};

    logic [SH_W-1:0]  aligned;
    logic [IP_W-1:0]  ipart;
    logic             guard, sticky, too_big, tiny, inc, ovf;
    logic [MAG_W-1:0] mag;
    logic [INT_W-1:0] mag_lo;

    always_comb begin
        too_big = fld_i.exp > $signed(EXPS_W'(INT_W));
        tiny    = fld_i.exp < $signed(-EXPS_W'(1));
        aligned = '0;
        if (!too_big && !tiny) begin
            aligned = SH_W'(fld_i.mant) << (int'(fld_i.exp) + 1);
        end
        if (tiny) begin
            ipart  = '0;
            guard  = 1'b0;
            sticky = |fld_i.mant;
        end else begin
            ipart  = aligned[SH_W-1:MANT_W];
            guard  = aligned[MANT_W-1];
            sticky = |aligned[MANT_W-2:0];
        end
    end

    always_comb begin
        unique case (rmode_i)
            RM_NEAR:  inc = guard & (sticky | ipart[0]);
            RM_ZERO:  inc = 1'b0;
            RM_PLUS:  inc = ~fld_i.sign & (guard | sticky);
            RM_MINUS: inc = fld_i.sign & (guard | sticky);
            default:  inc = 1'b0;
        endcase
    end

    always_comb begin
        mag       = MAG_W'(ipart) + MAG_W'(inc);
        mag_lo    = mag[INT_W-1:0];
        ovf       = too_big | (mag > (fld_i.sign ? NEG_LIM : POS_LIM));
        invalid_o = ovf;
        inexact_o = ~ovf & (guard | sticky);
        if (ovf)             result_o = SAT_VAL;
        else if (fld_i.sign) result_o = -mag_lo;
        else                 result_o = mag_lo;
    end
endmodule

// File: rtl/fp2int_trap_unit.sv
module fp2int_trap_unit
    import fcvt_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_dbl,
    input  logic [63:0]      in_opnd,
    input  logic [1:0]       in_rmode,
    output logic             out_wr_en,
    output logic [INT_W-1:0] out_result,
    output logic             out_cause_unimpl,
    output logic             out_cause_invalid,
    output logic             out_cause_inexact,
    output logic             out_irq
);
    opnd_fields_t     fld;
    logic [INT_W-1:0] conv_res;
    logic             conv_inv, conv_inx;
    cvt_state_e       state_q, state_d;
    logic [INT_W-1:0] result_q;
    logic             inv_q, inx_q;

    fcvt_unpack u_unpack (
        .dbl_i  (in_dbl),
        .opnd_i (in_opnd),
        .fld_o  (fld)
    );

    fcvt_round #(.INT_W(INT_W)) u_round (
        .fld_i     (fld),
        .rmode_i   (rmode_e'(in_rmode)),
        .result_o  (conv_res),
        .invalid_o (conv_inv),
        .inexact_o (conv_inx)
    );

    // next-state choice is the same from every state
    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_WRITE, ST_TRAP: begin
                if (!in_valid)        state_d = ST_IDLE;   // GO_IDLE
                else if (fld.special) state_d = ST_TRAP;   // GO_TRAP
                else                  state_d = ST_WRITE;  // GO_WRITE
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            inv_q    <= 1'b0;
            inx_q    <= 1'b0;
        end else begin
            unique case (state_d)
                ST_WRITE: begin
                    result_q <= conv_res;
                    inv_q    <= conv_inv;
                    inx_q    <= conv_inx;
                end
                ST_TRAP, ST_IDLE: begin
                    inv_q <= 1'b0;
                    inx_q <= 1'b0;
                end
                default: begin
                    inv_q <= 1'b0;
                    inx_q <= 1'b0;
                end
            endcase
        end
    end

    assign out_wr_en         = (state_q == ST_WRITE);
    assign out_irq           = (state_q == ST_TRAP);
    assign out_cause_unimpl  = (state_q == ST_TRAP);
    assign out_cause_invalid = inv_q;
    assign out_cause_inexact = inx_q;
    assign out_result        = result_q;

    // R4
    trap_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_irq |-> !out_wr_en);
    // R4
    trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_irq |-> $stable(out_result));
    // R5
    trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_irq |-> (out_cause_unimpl && !out_cause_invalid && !out_cause_inexact));
    // R11
    strobe_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_wr_en || out_irq || out_cause_invalid || out_cause_inexact) |-> $past(in_valid));
    // R9
    sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_cause_invalid |-> (out_wr_en && out_result == {1'b0, {(INT_W-1){1'b1}}}));
    // R10
    inexact_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_cause_inexact |-> (!out_cause_invalid && out_wr_en));
endmodule

// File: tb/sim_fp2int_trap_unit.sv
module sim_fp2int_trap_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_dbl = 1'b0;
    logic [63:0] in_opnd = '0;
    logic [1:0]  in_rmode = '0;
    logic        out_wr_en, out_cause_unimpl, out_cause_invalid, out_cause_inexact, out_irq;
    logic [31:0] out_result;

    int total = 0;
    int bad   = 0;
    logic [31:0] last_written = '0;

    always #2 clk = ~clk;

    fp2int_trap_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dbl(in_dbl),
        .in_opnd(in_opnd), .in_rmode(in_rmode), .out_wr_en(out_wr_en),
        .out_result(out_result), .out_cause_unimpl(out_cause_unimpl),
        .out_cause_invalid(out_cause_invalid), .out_cause_inexact(out_cause_inexact),
        .out_irq(out_irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic real opnd_value(input bit dbl, input logic [63:0] v);
        real m;
        if (dbl) return $bitstoreal(v);
        if (v[30:23] == 8'd0) m = real'(v[22:0]) * (2.0 ** -149.0);
        else m = (1.0 + real'(v[22:0]) / 8388608.0) * (2.0 ** (real'(v[30:23]) - 127.0));
        return v[31] ? -m : m;
    endfunction

    function automatic bit is_special(input bit dbl, input logic [63:0] v);
        return dbl ? (v[62:52] == 11'h7FF) : (v[30:23] == 8'hFF);
    endfunction

    // independent model of R6-R10
    task automatic model(input bit dbl, input logic [63:0] v, input logic [1:0] rm,
                         output logic [31:0] res, output bit inv, output bit inx);
        real x, fl, fr, r;
        x  = opnd_value(dbl, v);
        fl = $floor(x);
        fr = x - fl;
        case (rm)
            2'd0: begin
                if (fr > 0.5) r = fl + 1.0;
                else if (fr < 0.5) r = fl;
                else r = ((fl - 2.0 * $floor(fl / 2.0)) == 0.0) ? fl : fl + 1.0;
            end
            2'd1: r = (x >= 0.0) ? fl : ((fr == 0.0) ? fl : fl + 1.0);
            2'd2: r = (fr == 0.0) ? fl : fl + 1.0;
            default: r = fl;
        endcase
        if (r > 2147483647.0 || r < -2147483648.0) begin
            inv = 1'b1; inx = 1'b0; res = 32'h7FFFFFFF;
        end else begin
            inv = 1'b0; inx = (fr != 0.0);
            res = 32'($rtoi(r));
        end
    endtask

    task automatic run_one(input bit dbl, input logic [63:0] v, input logic [1:0] rm,
                           input string req);
        logic [31:0] eres;
        bit einv, einx, spec;
        spec = is_special(dbl, v);
        if (!spec) model(dbl, v, rm, eres, einv, einx);
        else begin eres = last_written; einv = 0; einx = 0; end
        @(negedge clk);
        in_valid = 1'b1; in_dbl = dbl; in_opnd = v; in_rmode = rm;
        @(negedge clk);
        in_valid = 1'b0; in_opnd = 64'hDEAD_BEEF_0BAD_F00D;
        chk(out_wr_en == !spec, req, "wr_en", out_wr_en, !spec);
        chk(out_irq == spec, req, "irq", out_irq, spec);
        chk(out_cause_unimpl == spec, req, "unimpl", out_cause_unimpl, spec);
        chk(out_result == eres, req, "result", out_result, eres);
        chk(out_cause_invalid == einv, req, "invalid", out_cause_invalid, einv);
        chk(out_cause_inexact == einx, req, "inexact", out_cause_inexact, einx);
        if (!spec) last_written = eres;
        @(negedge clk);
        // R11: no strobe, no outcome
        chk(!out_wr_en && !out_irq && !out_cause_unimpl && !out_cause_invalid
            && !out_cause_inexact, "R11", "idle flags",
            {out_wr_en, out_irq, out_cause_unimpl, out_cause_invalid, out_cause_inexact}, 0);
        chk(out_result == last_written, "R11", "result hold", out_result, last_written);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(out_result == 0 && !out_wr_en && !out_irq && !out_cause_unimpl &&
            !out_cause_invalid && !out_cause_inexact, "R1", "reset state",
            out_result, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_wr_en && !out_irq, "R1", "after reset", {out_wr_en, out_irq}, 0);
    endtask

    task automatic t_single_basic;   // R6 R2
        run_one(0, 64'h0000_0000_4120_0000, 2'd1, "R6");     // 10.0
        run_one(0, 64'h0000_0000_C2F6_0000, 2'd1, "R6");     // -123.0
        run_one(0, 64'hFFFF_FFFF_3FC0_0000, 2'd1, "R2");     // upper word ignored
        run_one(0, 64'h0000_0000_0000_0001, 2'd2, "R6");     // denormal toward +inf
    endtask

    task automatic t_double_basic;   // R6 R3
        run_one(1, 64'h4002_0000_0000_0000, 2'd0, "R6");     // 2.25
        run_one(1, 64'hC00C_0000_0000_0000, 2'd1, "R6");     // -3.5
        run_one(1, 64'h0000_0000_7F80_0000, 2'd0, "R3");     // single inf pattern in low word
    endtask

    task automatic t_modes;          // R7 R8
        for (int m = 0; m < 4; m++) begin
            run_one(0, 64'h0000_0000_3FC0_0000, 2'(m), "R7");  // 1.5
            run_one(0, 64'h0000_0000_C020_0000, 2'(m), "R7");  // -2.5
            run_one(1, 64'hC00C_0000_0000_0000, 2'(m), "R7");  // -3.5
        end
        run_one(0, 64'h0000_0000_4020_0000, 2'd0, "R8");     // 2.5 -> 2
        run_one(0, 64'h0000_0000_3F00_0000, 2'd0, "R8");     // 0.5 -> 0
        run_one(1, 64'h400C_0000_0000_0000, 2'd0, "R8");     // 3.5 -> 4
    endtask

    task automatic t_specials;       // R2 R3 R4 R5
        run_one(0, 64'h0000_0000_7F80_0000, 2'd0, "R4");     // +inf single
        run_one(0, 64'h0000_0000_FFC0_0001, 2'd1, "R5");     // NaN single
        run_one(1, 64'h7FF0_0000_0000_0000, 2'd2, "R3");     // +inf double
        run_one(1, 64'hFFF8_0000_0000_0000, 2'd3, "R5");     // NaN double
        run_one(0, 64'h7FF0_0000_4120_0000, 2'd1, "R2");     // upper inf ignored
        // back-to-back: trap then write
        @(negedge clk);
        in_valid = 1; in_dbl = 1; in_opnd = 64'h7FF0_0000_0000_0001; in_rmode = 0;
        @(negedge clk);
        chk(out_irq && !out_wr_en && out_result == last_written, "R4", "b2b trap",
            out_result, last_written);
        in_dbl = 0; in_opnd = 64'h0000_0000_4140_0000;       // 12.0
        @(negedge clk);
        in_valid = 0;
        chk(out_wr_en && !out_irq && out_result == 32'd12, "R6", "b2b write",
            out_result, 12);
        last_written = 32'd12;
    endtask

    task automatic t_range;          // R9 R10
        run_one(0, 64'h0000_0000_4F00_0000, 2'd1, "R9");     // 2^31
        run_one(0, 64'h0000_0000_CF00_0000, 2'd1, "R9");     // -2^31 exact
        run_one(1, 64'hC1E0_0000_0020_0000, 2'd1, "R9");     // -2^31-1
        run_one(1, 64'h7E37_E43C_8800_759C, 2'd0, "R9");     // 1e300
        for (int m = 0; m < 4; m++)
            run_one(1, 64'h41DF_FFFF_FFE0_0000, 2'(m), "R9"); // 2147483647.5
        run_one(1, 64'h41DF_FFFF_FFC0_0000, 2'd0, "R10");    // exact max
        run_one(1, 64'hC1DF_FFFF_FFE0_0000, 2'd3, "R10");    // -2147483647.5 down
        run_one(0, 64'h0000_0000_3E80_0000, 2'd1, "R10");    // 0.25
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_single_basic();
        t_double_basic();
        t_modes();
        t_specials();
        t_range();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule